// File: doc/BRIEF.md
# Per-Line Event Interrupt Controller

This block produces interrupts for one bank of general-purpose input lines. Each line passes through a short synchronizer. Detection then runs on the synchronized level, in a mode chosen per line. The mode can be a falling edge, a rising edge, either edge, a low level or a high level. A detected event latches a bit in a pending-status register. A line's mask bit decides whether its pending bit can drive the bank's single interrupt output.

Software drives the block over a simple register port:
- It sets mask bits by writing ones to an enable location and clears them by writing ones to a disable location.
- It reads the mask back.
- It takes pending events by reading the status location, and that read also clears them.

A service routine reads status, combines it with the mask, handles the lines it finds, and repeats until nothing is left. The per-line mode fields are held elsewhere and arrive as a packed vector with three bits per line.

Top module: `line_event_irq`

## Requirements
- R1: With mode code 0 a line sets its status bit on a synchronized 1-to-0 change. Code 1 sets it on a 0-to-1 change, and code 2 sets it on either change. The status bit becomes visible three clock edges after the pin changes: two synchronizer stages and one status edge.
- R2: With mode code 3 a line sets its status bit on every cycle its synchronized level is 0. Code 4 does the same while the level is 1. A level-mode bit therefore reappears right after a clearing read.
- R3: Mode codes 5, 6 and 7 never set a status bit.
- R4: A read at byte offset 0x2C returns the pending bits and clears them at that clock edge. An event detected in the same cycle as the read stays pending for the next read.
- R5: A write at offset 0x20 sets each mask bit whose data bit is 1. Zero data bits leave the mask unchanged.
- R6: A write at offset 0x24 clears each mask bit whose data bit is 1. Zero data bits leave the mask unchanged.
- R7: A read at offset 0x28 returns the mask, and the mask changes only through writes at 0x20 and 0x24.
- R8: `irqOut` is registered. At each edge it takes the OR over all lines of pending AND mask from the previous cycle, so a pending line whose mask bit is clear does not raise it.
- R9: After reset the mask, the status and `irqOut` are all zero.
- R10: A read at any other offset returns zero and does not clear status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | NUM_LINES | Raw line levels, asynchronous |
| eventSel | input | 3*NUM_LINES | Per-line mode codes, line i in bits [3i+2:3i] |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte offset |
| busWrData | input | NUM_LINES | Write data |
| busRdData | output | NUM_LINES | Read data, combinational from the current offset |
| irqOut | output | 1 | Bank interrupt |

## Verification
The bench builds the block at its defaults: 32 lines, a two-stage synchronizer and an 8-bit offset. This lets it drive every line of a full-width bank and place every mode code, including the three unused ones, on neighbouring lines at once. With the two-stage setting, the cycle of a status read can be lined up exactly with the cycle in which an edge is detected. A cycle-level reference model in the bench follows the random traffic, and directed steps cover the clear-on-read collision and the behaviour of masked lines.

// File: rtl/line_event_irq_pkg.sv
package line_event_irq_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FALL = 3'd0,
    MODE_RISE = 3'd1,
    MODE_BOTH = 3'd2,
    MODE_LOW  = 3'd3,
    MODE_HIGH = 3'd4
  } eventMode_e;

  localparam logic [7:0] OFFS_MASK_SET = 8'h20;
  localparam logic [7:0] OFFS_MASK_CLR = 8'h24;
  localparam logic [7:0] OFFS_MASK_RD  = 8'h28;
  localparam logic [7:0] OFFS_STATUS   = 8'h2C;

  typedef struct packed {
    logic setMask;
    logic clrMask;
    logic rdStatus;
    logic rdMask;
  } ctrlStrobe_t;

endpackage

// File: rtl/line_event_detect.sv
module line_event_detect
  import line_event_irq_pkg::*;
(
  input  logic [MODE_W-1:0] modeSel,
  input  logic              levelNow,
  input  logic              levelPrev,
  output logic              hit
);
  always_comb begin
    case (modeSel)
      MODE_FALL: hit = levelPrev & ~levelNow;
      MODE_RISE: hit = ~levelPrev & levelNow;
      MODE_BOTH: hit = levelPrev ^ levelNow;
      MODE_LOW:  hit = ~levelNow;
      MODE_HIGH: hit = levelNow;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/line_event_irq_ctrl.sv
module line_event_irq_ctrl
  import line_event_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] ADDR_SET  = ADDR_W'(OFFS_MASK_SET);
  localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(OFFS_MASK_CLR);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(OFFS_MASK_RD);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(OFFS_STATUS);

  always_comb begin
    strobe.setMask  = busWrEn && (busAddr == ADDR_SET);
    strobe.clrMask  = busWrEn && (busAddr == ADDR_CLR);
    strobe.rdStatus = busRdEn && (busAddr == ADDR_STAT);
    strobe.rdMask   = busRdEn && (busAddr == ADDR_MASK);
  end
endmodule

// File: rtl/line_event_irq_dp.sv
module line_event_irq_dp
  import line_event_irq_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        pinIn,
  input  logic [NUM_LINES*MODE_W-1:0] eventSel,
  input  ctrlStrobe_t                 strobe,
  input  logic [NUM_LINES-1:0]        wrData,
  output logic [NUM_LINES-1:0]        rdData,
  output logic                        irqOut,
  output logic [NUM_LINES-1:0]        statQ,
  output logic [NUM_LINES-1:0]        maskQ,
  output logic [NUM_LINES-1:0]        hitVec
);
  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] syncPipe;
  logic [NUM_LINES-1:0] levelNow;
  logic [NUM_LINES-1:0] levelPrev;
  logic [NUM_LINES-1:0] statNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe  <= '0;
      levelPrev <= '0;
    end else begin
      syncPipe  <= {syncPipe[SYNC_STAGES-2:0], pinIn};
      levelPrev <= levelNow;
    end
  end

  assign levelNow = syncPipe[SYNC_STAGES-1];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    line_event_detect u_det (
      .modeSel  (eventSel[i*MODE_W +: MODE_W]),
      .levelNow (levelNow[i]),
      .levelPrev(levelPrev[i]),
      .hit      (hitVec[i])
    );
  end

  // A clearing read drops only the bits that were visible; new hits survive.
  assign statNext = (strobe.rdStatus ? '0 : statQ) | hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ  <= '0;
      maskQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      statQ  <= statNext;
      if (strobe.setMask)      maskQ <= maskQ | wrData;
      else if (strobe.clrMask) maskQ <= maskQ & ~wrData;
      irqOut <= |(statQ & maskQ);
    end
  end

  always_comb begin
    if (strobe.rdStatus)    rdData = statQ;
    else if (strobe.rdMask) rdData = maskQ;
    else                    rdData = '0;
  end
endmodule

// File: rtl/line_event_irq.sv
module line_event_irq
  import line_event_irq_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        pinIn,
  input  logic [NUM_LINES*MODE_W-1:0] eventSel,
  input  logic                        busWrEn,
  input  logic                        busRdEn,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [NUM_LINES-1:0]        busWrData,
  output logic [NUM_LINES-1:0]        busRdData,
  output logic                        irqOut
);
  ctrlStrobe_t          strobe;
  logic [NUM_LINES-1:0] statQ;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] hitVec;

  line_event_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  line_event_irq_dp #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .eventSel(eventSel),
    .strobe  (strobe),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .irqOut  (irqOut),
    .statQ   (statQ),
    .maskQ   (maskQ),
    .hitVec  (hitVec)
  );
endmodule

// File: rtl/line_event_irq_chk.sv
module line_event_irq_chk
  import line_event_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_LINES*MODE_W-1:0] eventSel,
  input logic                        busWrEn,
  input logic                        busRdEn,
  input logic [ADDR_W-1:0]           busAddr,
  input logic [NUM_LINES-1:0]        busWrData,
  input logic                        irqOut,
  input logic [NUM_LINES-1:0]        statQ,
  input logic [NUM_LINES-1:0]        maskQ,
  input logic [NUM_LINES-1:0]        hitVec
);
  logic statRead, maskSet, maskClr;
  assign statRead = busRdEn && (busAddr == ADDR_W'(OFFS_STATUS));
  assign maskSet  = busWrEn && (busAddr == ADDR_W'(OFFS_MASK_SET));
  assign maskClr  = busWrEn && (busAddr == ADDR_W'(OFFS_MASK_CLR));

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(statQ & maskQ))));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    statRead |=> ((statQ & ~$past(hitVec)) == '0));

  assert_pending_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !statRead |=> ((statQ & $past(statQ)) == $past(statQ)));

  assert_enable_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    maskSet |=> (maskQ == ($past(maskQ) | $past(busWrData))));

  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    maskClr |=> (maskQ == ($past(maskQ) & ~$past(busWrData))));

  assert_mask_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(maskSet || maskClr) |=> $stable(maskQ));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_code
    assert_unused_code_R3: assert property (@(posedge clk) disable iff (!rstN)
      (eventSel[i*MODE_W +: MODE_W] > 3'd4) |-> !hitVec[i]);
  end
endmodule

bind line_event_irq line_event_irq_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .eventSel (eventSel),
  .busWrEn  (busWrEn),
  .busRdEn  (busRdEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .irqOut   (irqOut),
  .statQ    (statQ),
  .maskQ    (maskQ),
  .hitVec   (hitVec)
);

// File: tb/line_event_irq_bench.sv
`timescale 1ns/1ps
module line_event_irq_bench;
  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] pinIn = '0;
  logic [NL*3-1:0] eventSel = '1;
  logic          busWrEn = 1'b0;
  logic          busRdEn = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [NL-1:0] busWrData = '0;
  logic [NL-1:0] busRdData;
  logic          irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  line_event_irq u_line_event_irq (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .eventSel(eventSel),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  // Reference model built from the requirements.
  logic [NL-1:0] mS1, mS2, mPrev, mStat, mMask;
  logic          mIrq;

  function automatic logic [NL-1:0] detectFn(input logic [NL*3-1:0] sel,
                                             input logic [NL-1:0] cur,
                                             input logic [NL-1:0] prev);
    logic [NL-1:0] r;
    for (int i = 0; i < NL; i++) begin
      case (sel[i*3 +: 3])
        3'd0: r[i] = prev[i] & ~cur[i];
        3'd1: r[i] = ~prev[i] & cur[i];
        3'd2: r[i] = prev[i] ^ cur[i];
        3'd3: r[i] = ~cur[i];
        3'd4: r[i] = cur[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= '0; mS2 <= '0; mPrev <= '0; mStat <= '0; mMask <= '0; mIrq <= 1'b0;
    end else begin
      mS1   <= pinIn;
      mS2   <= mS1;
      mPrev <= mS2;
      mStat <= ((busRdEn && busAddr == 8'h2C) ? '0 : mStat) | detectFn(eventSel, mS2, mPrev);
      if (busWrEn && busAddr == 8'h20)      mMask <= mMask | busWrData;
      else if (busWrEn && busAddr == 8'h24) mMask <= mMask & ~busWrData;
      mIrq  <= |(mStat & mMask);
    end
  end

  task automatic check(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) check("R8 irqOut vs model", {31'b0, irqOut}, {31'b0, mIrq});
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [NL-1:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [NL-1:0] d);
    busRdEn = 1'b1; busAddr = a;
    #2 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  function automatic logic [NL*3-1:0] selOne(input int line, input logic [2:0] code);
    logic [NL*3-1:0] s = '1;
    s[line*3 +: 3] = code;
    return s;
  endfunction

  logic [NL-1:0] rd;

  initial begin
    void'($urandom(32'd1234));
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 irq after reset", {31'b0, irqOut}, '0);
    busRead(8'h28, rd); check("R9 mask after reset", rd, '0);
    busRead(8'h2C, rd); check("R9 status after reset", rd, '0);

    // R3: unused codes 5..7 on all lines
    for (int i = 0; i < NL; i++) eventSel[i*3 +: 3] = 3'(5 + (i % 3));
    pinIn = '1; waitCycles(5); pinIn = '0; waitCycles(5);
    busRead(8'h2C, rd); check("R3 unused codes", rd, '0);

    // R1: edge modes
    eventSel = '1;
    eventSel[2:0] = 3'd1; eventSel[5:3] = 3'd0; eventSel[8:6] = 3'd2;
    pinIn[2:0] = 3'b111; waitCycles(3);
    busRead(8'h2C, rd); check("R1 rising edges", rd, 32'h5);
    busRead(8'h2C, rd); check("R4 cleared by read", rd, '0);
    pinIn[2:0] = 3'b000; waitCycles(2);
    busRead(8'h2C, rd); check("R1 latency, not yet visible", rd, '0);
    busRead(8'h2C, rd); check("R1 falling edges", rd, 32'h6);

    // R2: level modes reappear
    eventSel = '1; eventSel[11:9] = 3'd4; eventSel[14:12] = 3'd3;
    pinIn[3] = 1'b1; pinIn[4] = 1'b0; waitCycles(4);
    busRead(8'h2C, rd); check("R2 levels first read", rd, 32'h18);
    busRead(8'h2C, rd); check("R2 levels reappear", rd, 32'h18);

    // R5/R6/R7: mask
    busWrite(8'h20, 32'hA5); busWrite(8'h20, 32'h0);
    busRead(8'h28, rd); check("R5 enable sets, zeros ignored", rd, 32'hA5);
    busWrite(8'h24, 32'h05); busWrite(8'h24, 32'h0);
    busRead(8'h28, rd); check("R6 disable clears, zeros ignored", rd, 32'hA0);
    busWrite(8'h2C, 32'hFF); busWrite(8'h28, 32'hFF);
    busRead(8'h28, rd); check("R7 mask unchanged by other writes", rd, 32'hA0);

    // R8: masked pending lines do not raise irq
    waitCycles(3);
    check("R8 masked pending keeps irq low", {31'b0, irqOut}, '0);
    busWrite(8'h20, 32'h08); @(negedge clk);
    check("R8 unmasked pending raises irq", {31'b0, irqOut}, 32'h1);
    busWrite(8'h24, 32'h08); @(negedge clk);
    check("R8 irq drops after disable", {31'b0, irqOut}, '0);

    // R4: event in same cycle as read is kept
    eventSel = selOne(6, 3'd1); pinIn = '0; waitCycles(4);
    busRead(8'h2C, rd);
    pinIn[6] = 1'b1; @(posedge clk); @(posedge clk); @(negedge clk);
    busRead(8'h2C, rd); check("R4 colliding read misses new event", rd, '0);
    busRead(8'h2C, rd); check("R4 colliding event kept", rd, 32'h40);

    // R10: other offset reads give zero and do not clear
    eventSel = selOne(6, 3'd2); pinIn[6] = 1'b0; waitCycles(4);
    busRead(8'h08, rd); check("R10 other offset reads zero", rd, '0);
    busRead(8'h2C, rd); check("R10 status not cleared", rd, 32'h40);

    // Random phase against the model
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int op;
      if ($urandom % 50 == 0)
        for (int i = 0; i < NL; i++) eventSel[i*3 +: 3] = 3'($urandom % 8);
      pinIn = pinIn ^ ($urandom & $urandom & $urandom);
      op = $urandom % 6;
      case (op)
        0: busWrite(8'h20, $urandom & $urandom);
        1: busWrite(8'h24, $urandom);
        2: begin
             busRdEn = 1'b1; busAddr = 8'h2C; #2;
             check("R4 random status read", busRdData, mStat);
             @(negedge clk); busRdEn = 1'b0;
           end
        3: begin
             busRdEn = 1'b1; busAddr = 8'h28; #2;
             check("R7 random mask read", busRdData, mMask);
             @(negedge clk); busRdEn = 1'b0;
           end
        default: @(negedge clk);
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule